// File: doc/BRIEF.md
# Charge Status Indicator Driver

This block turns the charger's encoded operating state into the drive for one open-drain status pin. The pin can only be pulled low or released, so the block's single output is a pull-low enable: `pull_en = 1` pulls the pin low, and `pull_en = 0` releases it, so the external pull-up makes it read high.

Active charging holds the pin low. Finished, idle and disabled states release it. Either kind of suspend fault makes it blink at a rate derived from the system clock frequency. A software-owned disable bit overrides the whole mapping and leaves the pin released.

All inputs are plain control levels sampled on the rising clock edge. Every change in the output appears after exactly one edge. There is no data stream and no handshake.

Top module: `stat_pin_driver`

## Requirements
- R1: While `rst_n` is low, and after reset until the first edge with a new input, `pull_en` is 0 (pin released).
- R2: With `stat_off` = 0 and `state_code` 0 (charging) or 1 (recharging), `pull_en` is 1 after the next rising edge.
- R3: With `stat_off` = 0 and `state_code` 2 (done), 3 (sleep), 4 (charging disabled) or 7 (unused), `pull_en` is 0 after the next rising edge.
- R4: With `stat_off` = 0 and `state_code` 5 (charge suspend fault) or 6 (boost suspend fault) held, `pull_en` alternates between 1 and 0. Each level lasts HALF = CLK_HZ/(2*BLINK_HZ) cycles, which gives a 50 % duty cycle.
- R5: On entry into blinking from any non-blinking condition (another code, or `stat_off` falling), `pull_en` is 1 for the first HALF cycles, counted from the first edge that sees the blinking condition.
- R6: Switching directly between codes 5 and 6 does not restart the blink phase.
- R7: `stat_off` = 1 makes `pull_en` 0 after the next rising edge, whatever `state_code` is, including in the middle of a blink half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_code | input | 3 | Encoded charger state (codes listed in R2 to R4) |
| stat_off | input | 1 | 1 turns the indicator function off (pin released) |
| pull_en | output | 1 | 1 pulls the pin low, 0 releases it |

## Verification
A blink toggle and a mode change can land on the same edge: the half-period counter expires just as `stat_off` rises or the state leaves the fault codes. The bench provokes this by counting cycles from a known blink entry and asserting `stat_off` on exactly the edge where the toggle falls due. It expects a released pin on that edge. It then lowers `stat_off` and expects the blink to restart with a full low half-period rather than resume the old phase.

// File: rtl/stat_pkg.sv
package stat_pkg;
  typedef enum logic [2:0] {
    ST_CHARGING      = 3'd0,
    ST_RECHARGING    = 3'd1,
    ST_DONE          = 3'd2,
    ST_SLEEP         = 3'd3,
    ST_CHG_OFF       = 3'd4,
    ST_CHG_SUSPEND   = 3'd5,
    ST_BOOST_SUSPEND = 3'd6,
    ST_UNUSED        = 3'd7
  } chg_state_e;

  typedef enum logic [1:0] {
    MODE_RELEASE = 2'd0,
    MODE_PULL    = 2'd1,
    MODE_BLINK   = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/stat_mode_decode.sv
module stat_mode_decode
  import stat_pkg::*;
(
  input  logic [2:0] state_code,
  input  logic       stat_off,
  output pin_mode_e  mode
);
  always_comb begin
    mode = MODE_RELEASE;
    if (!stat_off) begin
      case (chg_state_e'(state_code))
        ST_CHARGING, ST_RECHARGING:        mode = MODE_PULL;    // R2
        ST_CHG_SUSPEND, ST_BOOST_SUSPEND:  mode = MODE_BLINK;   // R4
        default:                           mode = MODE_RELEASE; // R3
      endcase
    end
  end
endmodule

// File: rtl/stat_blink_gen.sv
module stat_blink_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blink_req,     // next mode is blink
  input  logic blink_active,  // current mode is blink
  output logic phase_low
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  // Counting only continues when blink was already active: R5 restart, R6 carry-on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      phase_low <= 1'b1;
    end else if (blink_req && blink_active) begin
      if (cnt_q == LAST) begin
        cnt_q     <= '0;
        phase_low <= ~phase_low;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q     <= '0;
      phase_low <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_pin_driver.sv
module stat_pin_driver
  import stat_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned BLINK_HZ = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] state_code,
  input  logic       stat_off,
  output logic       pull_en
);
  localparam int unsigned HALF_RAW = CLK_HZ / (2 * BLINK_HZ);
  localparam int unsigned HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  pin_mode_e mode_d, mode_q;
  logic      phase_low;

  stat_mode_decode u_dec (
    .state_code (state_code),
    .stat_off   (stat_off),
    .mode       (mode_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RELEASE;  // R1
    else        mode_q <= mode_d;
  end

  stat_blink_gen #(.HALF(HALF)) u_blink (
    .clk          (clk),
    .rst_n        (rst_n),
    .blink_req    (mode_d == MODE_BLINK),
    .blink_active (mode_q == MODE_BLINK),
    .phase_low    (phase_low)
  );

  assign pull_en = (mode_q == MODE_PULL) || ((mode_q == MODE_BLINK) && phase_low);
endmodule

// File: rtl/stat_pin_checker.sv
module stat_pin_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_code,
  input logic       stat_off,
  input logic       pull_en
);
  logic fault_code, was_blink;
  assign fault_code = (state_code == 3'd5) || (state_code == 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_blink <= 1'b0;
    else        was_blink <= !stat_off && fault_code;
  end

  a_r1_reset_released: assert property (@(posedge clk) !rst_n |-> !pull_en);

  a_r2_charge_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_off && (state_code == 3'd0 || state_code == 3'd1)) |=> pull_en);

  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_off && (state_code == 3'd2 || state_code == 3'd3 ||
                   state_code == 3'd4 || state_code == 3'd7)) |=> !pull_en);

  a_r5_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_off && fault_code && !was_blink) |=> pull_en);

  a_r7_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    stat_off |=> !pull_en);
endmodule

bind stat_pin_driver stat_pin_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_code (state_code),
  .stat_off   (stat_off),
  .pull_en    (pull_en)
);

// File: tb/sim_stat_pin_driver.sv
`timescale 1ns/1ps
module sim_stat_pin_driver;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] state_code = 3'd2;
  logic       stat_off = 1'b0;
  logic       pull_en;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  stat_pin_driver #(.CLK_HZ(2 * HALF), .BLINK_HZ(1)) u0 (
    .clk(clk), .rst_n(rst_n), .state_code(state_code),
    .stat_off(stat_off), .pull_en(pull_en)
  );

  // {stat_off, state_code[2:0], expected pull_en}
  localparam logic [4:0] VEC [12] = '{
    {1'b0, 3'd0, 1'b1}, {1'b0, 3'd2, 1'b0}, {1'b0, 3'd1, 1'b1},
    {1'b0, 3'd3, 1'b0}, {1'b0, 3'd0, 1'b1}, {1'b0, 3'd4, 1'b0},
    {1'b0, 3'd1, 1'b1}, {1'b0, 3'd7, 1'b0}, {1'b1, 3'd0, 1'b0},
    {1'b1, 3'd1, 1'b0}, {1'b1, 3'd5, 1'b0}, {1'b1, 3'd6, 1'b0}
  };

  task automatic check(input logic exp, input string req);
    n_run++;
    if (pull_en !== exp) begin
      n_fail++;
      $display("FAIL %s: pull_en=%b expected %b at %0t", req, pull_en, exp, $time);
    end
  endtask

  // called at a falling edge: drive, pass one rising edge, return at next falling edge
  task automatic step(input logic off, input logic [2:0] code);
    stat_off   = off;
    state_code = code;
    @(negedge clk);
  endtask

  function automatic logic blink_exp(input int i);
    return ((i / HALF) % 2) == 0;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run hung");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after reset");

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][4], VEC[i][3:1]);
      check(VEC[i][0], VEC[i][4] ? "R7 off" : (VEC[i][0] ? "R2 charging" : "R3 released"));
    end

    // R4/R5: entry from done, full blink pattern over three half-periods
    step(1'b0, 3'd2);
    for (int i = 0; i < 3 * HALF; i++) begin
      step(1'b0, 3'd5);
      check(blink_exp(i), i < HALF ? "R5 entry low" : "R4 blink");
    end

    // R6: switch 5 -> 6 mid-pattern keeps phase
    step(1'b0, 3'd2);
    for (int i = 0; i < 3 * HALF; i++) begin
      step(1'b0, (i < HALF + 1) ? 3'd5 : 3'd6);
      check(blink_exp(i), "R6 no restart on 5->6");
    end

    // R7 collision: disable on the edge where the toggle falls due
    step(1'b0, 3'd2);
    for (int i = 0; i < HALF; i++) begin
      step(1'b0, 3'd6);
      check(1'b1, "R5 entry low");
    end
    step(1'b1, 3'd6);
    check(1'b0, "R7 off at toggle edge");
    for (int i = 0; i < HALF + 1; i++) begin
      step(1'b0, 3'd6);
      check(blink_exp(i), "R5 restart after off");
    end

    // leaving blink on a toggle edge into charging
    step(1'b0, 3'd2);
    for (int i = 0; i < HALF; i++) step(1'b0, 3'd5);
    step(1'b0, 3'd0);
    check(1'b1, "R2 charging after blink");

    // reset in the middle of charging
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    stat_off = 1'b0;
    state_code = 3'd2;
    @(negedge clk);
    check(1'b0, "R1 released after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule